// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Set/Clear Aliases

This block controls a 16-pin general-purpose I/O port from a simple memory-mapped register bus. The bus carries a byte offset, an access size in bytes, and separate read and write strobes. The port holds five registers:

- a function-enable mask;
- an output data latch, reachable directly and through write-one-to-set and write-one-to-clear aliases;
- a hidden direction mask, which can only be changed through its own set and clear aliases;
- an input-enable mask;
- a 32-bit pin-multiplexing word.

Writes that can change what the pins drive schedule a refresh of the output pins. Incoming pin levels are passed on only for pins that are inputs, input-enabled and function-enabled.

Each access is checked for width before its address is checked. Rejected accesses write nothing and return zero. They raise one of two one-cycle error flags. Read data and error flags are registered and appear in the cycle after the strobe.

Top module: `gpio_alias_port`

## Requirements
- R1: After a synchronous active-high reset, every register, including the hidden direction mask, is zero. `pin_out`, `in_data`, `in_valid`, `bus_rdata` and both error flags are also zero.
- R2: The offsets are: function enable 0x00, data 0x04, data-set 0x08, data-clear 0x0C, direction-set 0x10, direction-clear 0x14, input enable 0x18, mux 0x1C. A write to function enable, data or input enable stores `bus_wdata[15:0]`; a write to mux stores all 32 bits. A read returns the register, zero-extended, on `bus_rdata` in the cycle after the strobe. `bus_rdata` is zero in every cycle that does not follow an accepted read.
- R3: `bus_size` is a byte count. The mux offset accepts only size 4, and every other offset accepts only size 2. Any other size pulses `bus_err_width` for one cycle after the strobe. In that case nothing is written and `bus_rdata` is zero.
- R4: An offset that is not a multiple of 4, or is 0x20 or above, pulses `bus_err_addr` for one cycle after the strobe. Nothing is written and `bus_rdata` is zero.
- R5: An access that has both a wrong size and an unmapped offset reports only `bus_err_width`. The two flags are never high together.
- R6: A write to data-set ORs `bus_wdata[15:0]` into data. A write to data-clear clears each data bit where the written value has a 1. Reads of data, data-set and data-clear all return data.
- R7: Direction-set ORs the written bits into the direction mask, and direction-clear clears the written 1 bits. A read of either direction alias returns the direction mask.
- R8: A write to data, data-set, data-clear or direction-set refreshes the pins on the second clock edge after the strobe edge. Each pin whose input-enable bit is 0 then drives its data bit.
- R9: During a refresh, pins whose input-enable bit is 1 keep the value they already drive.
- R10: Writes to direction-clear, function enable, input enable and mux never change `pin_out`.
- R11: `in_valid[i]` is 1 exactly when direction bit i is 0, input-enable bit i is 1 and function-enable bit i is 1. `in_data[i]` is `pin_in[i]` for those pins and 0 for all others. Both are registered, one cycle behind their inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access size in bytes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err_width | output | 1 | One-cycle pulse: access size rejected |
| bus_err_addr | output | 1 | One-cycle pulse: offset not mapped |
| pin_in | input | 16 | Incoming pin levels |
| pin_out | output | 16 | Driven pin values |
| in_data | output | 16 | Qualified input levels |
| in_valid | output | 16 | Per-pin qualification strobe |

## Verification
Directed sequences cover the following cases:

- Alias writes on overlapping bit patterns separate a true OR or AND-NOT from a plain overwrite.
- Setting input-enable before a data write, and later issuing a direction-clear write, shows whether pins hold their value and whether the wrong writes trigger a refresh.
- The offsets 0x1C with size 2, 0x22 with size 4 and 0x22 with size 2 separate width errors, address errors and their priority.

Random accesses then mix mapped and arbitrary offsets, all sizes, and reads and writes. Random pin levels are applied under random masks, which exposes any mistake in the three-mask qualification.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;

  // Register slots; the slot number times the stride is the byte offset.
  localparam int unsigned REG_STRIDE = 4;
  localparam int unsigned REG_COUNT  = 8;
  localparam int unsigned SEL_LSB    = $clog2(REG_STRIDE);
  localparam int unsigned SEL_W      = $clog2(REG_COUNT);
  localparam int unsigned WINDOW     = REG_COUNT * REG_STRIDE;

  typedef enum logic [SEL_W-1:0] {
    RS_FUNC   = 3'd0,
    RS_DATA   = 3'd1,
    RS_DSET   = 3'd2,
    RS_DCLR   = 3'd3,
    RS_DIRSET = 3'd4,
    RS_DIRCLR = 3'd5,
    RS_INEN   = 3'd6,
    RS_MUX    = 3'd7
  } reg_sel_e;

  localparam int unsigned MUX_OFFSET   = int'(RS_MUX) * REG_STRIDE;
  localparam logic [2:0]  NARROW_BYTES = 3'd2;
  localparam logic [2:0]  WIDE_BYTES   = 3'd4;

  // Access width demanded by an offset.
  function automatic logic [2:0] needed_bytes(input logic wide_slot);
    return wide_slot ? WIDE_BYTES : NARROW_BYTES;
  endfunction

  // Writes that change what the pins drive.
  function automatic logic triggers_refresh(input reg_sel_e s);
    return (s == RS_DATA) || (s == RS_DSET) || (s == RS_DCLR) || (s == RS_DIRSET);
  endfunction

endpackage

// File: rtl/gpio_alias_decode.sv
module gpio_alias_decode
  import gpio_alias_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic              strobe,
  output reg_sel_e          sel,
  output logic              acc_ok,
  output logic              err_width,
  output logic              err_addr
);

  localparam int unsigned ALIGN_W = SEL_LSB;

  logic wide_slot;
  logic width_bad;
  logic aligned;
  logic in_window;

  assign wide_slot = (32'(addr) == MUX_OFFSET);
  assign width_bad = (size != needed_bytes(wide_slot));
  assign aligned   = (addr[ALIGN_W-1:0] == '0);
  assign in_window = (32'(addr) < WINDOW);
  assign sel       = reg_sel_e'(addr[SEL_LSB +: SEL_W]);

  // Width is judged first; only a correctly sized access can miss the map.
  assign err_width = strobe && width_bad;
  assign err_addr  = strobe && !width_bad && !(aligned && in_window);
  assign acc_ok    = strobe && !width_bad && aligned && in_window;

endmodule

// File: rtl/gpio_alias_regs.sv
module gpio_alias_regs
  import gpio_alias_pkg::*;
#(
  parameter int unsigned PINS  = 16,
  parameter int unsigned MUX_W = 32,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [PINS-1:0]  fer_q,
  output logic [PINS-1:0]  data_q,
  output logic [PINS-1:0]  dir_q,
  output logic [PINS-1:0]  inen_q,
  output logic [BUS_W-1:0] rdata_q,
  output logic             refresh_q
);

  logic [MUX_W-1:0] mux_q;
  logic [PINS-1:0]  wnarrow;
  logic [PINS-1:0]  data_set_n, data_clr_n, dir_set_n, dir_clr_n;
  logic [BUS_W-1:0] rd_val;

  function automatic logic [PINS-1:0] or_in(input logic [PINS-1:0] cur,
                                            input logic [PINS-1:0] val);
    return cur | val;
  endfunction

  function automatic logic [PINS-1:0] knock_out(input logic [PINS-1:0] cur,
                                                input logic [PINS-1:0] val);
    return cur & ~val;
  endfunction

  assign wnarrow    = wdata[PINS-1:0];
  assign data_set_n = or_in(data_q, wnarrow);
  assign data_clr_n = knock_out(data_q, wnarrow);
  assign dir_set_n  = or_in(dir_q, wnarrow);
  assign dir_clr_n  = knock_out(dir_q, wnarrow);

  always_comb begin
    unique case (sel)
      RS_FUNC:                   rd_val = BUS_W'(fer_q);
      RS_DATA, RS_DSET, RS_DCLR: rd_val = BUS_W'(data_q);
      RS_DIRSET, RS_DIRCLR:      rd_val = BUS_W'(dir_q);
      RS_INEN:                   rd_val = BUS_W'(inen_q);
      RS_MUX:                    rd_val = BUS_W'(mux_q);
      default:                   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fer_q     <= '0;
      data_q    <= '0;
      dir_q     <= '0;
      inen_q    <= '0;
      mux_q     <= '0;
      rdata_q   <= '0;
      refresh_q <= 1'b0;
    end else begin
      refresh_q <= wr_en && triggers_refresh(sel);
      rdata_q   <= rd_en ? rd_val : '0;
      if (wr_en) begin
        unique case (sel)
          RS_FUNC:   fer_q  <= wnarrow;
          RS_DATA:   data_q <= wnarrow;
          RS_DSET:   data_q <= data_set_n;
          RS_DCLR:   data_q <= data_clr_n;
          RS_DIRSET: dir_q  <= dir_set_n;
          RS_DIRCLR: dir_q  <= dir_clr_n;
          RS_INEN:   inen_q <= wnarrow;
          RS_MUX:    mux_q  <= wdata[MUX_W-1:0];
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_alias_pins.sv
module gpio_alias_pins #(
  parameter int unsigned PINS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            refresh,
  input  logic [PINS-1:0] data,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] inen,
  input  logic [PINS-1:0] fer,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] in_data,
  output logic [PINS-1:0] in_valid
);

  logic [PINS-1:0] qual;
  logic [PINS-1:0] level;

  // Input-enabled pins hold their value; the rest take the data bits.
  function automatic logic [PINS-1:0] drive_mix(input logic [PINS-1:0] prev,
                                                input logic [PINS-1:0] dat,
                                                input logic [PINS-1:0] hold);
    return (prev & hold) | (dat & ~hold);
  endfunction

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    assign qual[g]  = !dir[g] && inen[g] && fer[g];
    assign level[g] = qual[g] && pin_in[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out  <= '0;
      in_data  <= '0;
      in_valid <= '0;
    end else begin
      if (refresh) pin_out <= drive_mix(pin_out, data, inen);
      in_valid <= qual;
      in_data  <= level;
    end
  end

endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
  import gpio_alias_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PINS   = 16,
  parameter int unsigned MUX_W  = 32,
  parameter int unsigned BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_err_width,
  output logic              bus_err_addr,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   in_data,
  output logic [PINS-1:0]   in_valid
);

  // Named internal events.
  logic     acc_strobe;
  logic     acc_ok;
  logic     wr_fire;
  logic     rd_fire;
  logic     refresh_evt;
  logic     err_w_n, err_a_n;
  reg_sel_e sel;
  logic [PINS-1:0] fer_q, data_q, dir_q, inen_q;

  assign acc_strobe = bus_wr || bus_rd;
  assign wr_fire    = acc_ok && bus_wr;
  assign rd_fire    = acc_ok && bus_rd && !bus_wr;

  gpio_alias_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (bus_addr),
    .size      (bus_size),
    .strobe    (acc_strobe),
    .sel       (sel),
    .acc_ok    (acc_ok),
    .err_width (err_w_n),
    .err_addr  (err_a_n)
  );

  gpio_alias_regs #(.PINS(PINS), .MUX_W(MUX_W), .BUS_W(BUS_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_fire),
    .rd_en     (rd_fire),
    .sel       (sel),
    .wdata     (bus_wdata),
    .fer_q     (fer_q),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .inen_q    (inen_q),
    .rdata_q   (bus_rdata),
    .refresh_q (refresh_evt)
  );

  gpio_alias_pins #(.PINS(PINS)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .refresh  (refresh_evt),
    .data     (data_q),
    .dir      (dir_q),
    .inen     (inen_q),
    .fer      (fer_q),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .in_data  (in_data),
    .in_valid (in_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_err_width <= 1'b0;
      bus_err_addr  <= 1'b0;
    end else begin
      bus_err_width <= err_w_n;
      bus_err_addr  <= err_a_n;
    end
  end

endmodule

// File: rtl/gpio_alias_port_chk.sv
module gpio_alias_port_chk
  import gpio_alias_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PINS   = 16,
  parameter int unsigned BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_err_width,
  input logic              bus_err_addr,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   in_valid,
  input logic [PINS-1:0]   dir_q,
  input logic [PINS-1:0]   inen_q,
  input logic              refresh_evt
);

  // R5: the two error flags never coincide.
  assert_err_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(bus_err_width && bus_err_addr));

  // R3: a rejected access returns zero data.
  assert_err_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_err_width || bus_err_addr) |-> (bus_rdata == '0));

  // R3: a narrow access to the mux slot is a width error.
  assert_mux_width_R3: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && (32'(bus_addr) == MUX_OFFSET) && (bus_size != 3'd4))
      |=> bus_err_width);

  // R5: a bad width off the mux slot reports width, never address.
  assert_prio_R5: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && (32'(bus_addr) != MUX_OFFSET) && (bus_size != 3'd2))
      |=> (bus_err_width && !bus_err_addr));

  // R2: without a preceding read the data bus is zero.
  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));

  // R10: pins move only after a refresh event.
  assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(refresh_evt) |-> $stable(pin_out));

  // R9: input-enabled pins keep their value through a refresh.
  assert_pin_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $past(refresh_evt) |-> (((pin_out ^ $past(pin_out)) & $past(inen_q)) == '0));

  // R11: output-direction pins never report a valid input.
  assert_in_dir_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid & $past(dir_q)) == '0);

endmodule

bind gpio_alias_port gpio_alias_port_chk #(
  .ADDR_W(ADDR_W), .PINS(PINS), .BUS_W(BUS_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bus_addr      (bus_addr),
  .bus_size      (bus_size),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_rdata     (bus_rdata),
  .bus_err_width (bus_err_width),
  .bus_err_addr  (bus_err_addr),
  .pin_out       (pin_out),
  .in_valid      (in_valid),
  .dir_q         (dir_q),
  .inen_q        (inen_q),
  .refresh_evt   (refresh_evt)
);

// File: tb/gpio_alias_port_tb.sv
module gpio_alias_port_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err_width, bus_err_addr;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, in_data, in_valid;

  int checks = 0;
  int fails  = 0;

  // Reference state.
  logic [15:0] m_fer = '0, m_data = '0, m_dir = '0, m_inen = '0, m_pin = '0;
  logic [31:0] m_mux = '0;

  always #5 clk = ~clk;

  gpio_alias_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err_width(bus_err_width),
    .bus_err_addr(bus_err_addr), .pin_in(pin_in), .pin_out(pin_out),
    .in_data(in_data), .in_valid(in_valid)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // {width error, address error} expected for an access.
  function automatic logic [1:0] exp_err(input logic [7:0] a, input logic [2:0] s);
    logic need_wide;
    need_wide = (a == 8'h1C);
    if (need_wide ? (s != 3'd4) : (s != 3'd2)) return 2'b10;
    if ((a % 4) != 0 || a >= 8'h20) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:               return {16'h0, m_fer};
      8'h04, 8'h08, 8'h0C: return {16'h0, m_data};
      8'h10, 8'h14:        return {16'h0, m_dir};
      8'h18:               return {16'h0, m_inen};
      8'h1C:               return m_mux;
      default:             return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] w);
    case (a)
      8'h00: m_fer  = w[15:0];
      8'h04: m_data = w[15:0];
      8'h08: m_data = m_data | w[15:0];
      8'h0C: m_data = m_data & ~w[15:0];
      8'h10: m_dir  = m_dir | w[15:0];
      8'h14: m_dir  = m_dir & ~w[15:0];
      8'h18: m_inen = w[15:0];
      8'h1C: m_mux  = w;
      default: ;
    endcase
    if (a == 8'h04 || a == 8'h08 || a == 8'h0C || a == 8'h10)
      m_pin = (m_pin & m_inen) | (m_data & ~m_inen);
  endtask

  // One access, then checks of flags, read data and the refreshed pins.
  task automatic access(input logic wr, input logic [7:0] a, input logic [2:0] s,
                        input logic [31:0] w, input string req);
    logic [1:0]  e;
    logic [31:0] rexp;
    e    = exp_err(a, s);
    rexp = (!wr && e == 2'b00) ? exp_read(a) : 32'h0;
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = w; bus_wr = wr; bus_rd = !wr;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check({req, " width flag (R3/R5)"}, {31'h0, bus_err_width}, {31'h0, e[1]});
    check({req, " addr flag (R4/R5)"},  {31'h0, bus_err_addr},  {31'h0, e[0]});
    check({req, " rdata (R2)"}, bus_rdata, rexp);
    if (wr && e == 2'b00) model_write(a, w);
    @(negedge clk);
    check({req, " pin_out (R8/R9/R10)"}, {16'h0, pin_out}, {16'h0, m_pin});
  endtask

  task automatic input_check(input logic [15:0] lv, input string req);
    logic [15:0] q;
    q = ~m_dir & m_inen & m_fer;
    @(negedge clk);
    pin_in = lv;
    @(negedge clk);
    check({req, " in_valid (R11)"}, {16'h0, in_valid}, {16'h0, q});
    check({req, " in_data (R11)"},  {16'h0, in_data},  {16'h0, lv & q});
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state.
    check("R1 pin_out", {16'h0, pin_out}, 32'h0);
    check("R1 in_valid", {16'h0, in_valid}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 err", {30'h0, bus_err_width, bus_err_addr}, 32'h0);
    for (int i = 0; i < 7; i++) access(1'b0, 8'(i * 4), 3'd2, 32'h0, "R1 read zero");
    access(1'b0, 8'h1C, 3'd4, 32'h0, "R1 mux zero");

    // R2: direct registers, upper write bits dropped on narrow ones.
    access(1'b1, 8'h00, 3'd2, 32'hDEAD_5A5A, "R2 fer write");
    access(1'b0, 8'h00, 3'd2, 32'h0, "R2 fer read");
    access(1'b1, 8'h1C, 3'd4, 32'hCAFE_F00D, "R2 mux write");
    access(1'b0, 8'h1C, 3'd4, 32'h0, "R2 mux read");

    // R6 / R8: data and its aliases with all pins driving.
    access(1'b1, 8'h04, 3'd2, 32'h0000_00FF, "R8 data write");
    access(1'b1, 8'h08, 3'd2, 32'h0000_0F0F, "R6 data set");
    access(1'b1, 8'h0C, 3'd2, 32'h0000_00F3, "R6 data clear");
    access(1'b0, 8'h08, 3'd2, 32'h0, "R6 read via set");
    access(1'b0, 8'h0C, 3'd2, 32'h0, "R6 read via clear");

    // R7: direction aliases.
    access(1'b1, 8'h10, 3'd2, 32'h0000_3C3C, "R7 dir set");
    access(1'b1, 8'h14, 3'd2, 32'h0000_0C00, "R7 dir clear");
    access(1'b0, 8'h10, 3'd2, 32'h0, "R7 read dir set");
    access(1'b0, 8'h14, 3'd2, 32'h0, "R7 read dir clear");

    // R9 / R10: hold with input-enable, no refresh from dir-clear.
    access(1'b1, 8'h18, 3'd2, 32'h0000_FFFF, "R10 inen all");
    access(1'b1, 8'h04, 3'd2, 32'h0000_AAAA, "R9 hold write");
    access(1'b1, 8'h18, 3'd2, 32'h0000_0000, "R10 inen none");
    access(1'b1, 8'h14, 3'd2, 32'h0000_0001, "R10 dir clear quiet");
    access(1'b1, 8'h00, 3'd2, 32'h0000_1234, "R10 fer quiet");
    access(1'b1, 8'h10, 3'd2, 32'h0000_0000, "R8 dir set refresh");
    access(1'b1, 8'h18, 3'd2, 32'h0000_F0F0, "R9 inen half");
    access(1'b1, 8'h04, 3'd2, 32'h0000_5555, "R9 partial hold");

    // R3 / R4 / R5: error paths; mux and data stay unchanged.
    access(1'b1, 8'h1C, 3'd2, 32'h1111_1111, "R3 mux narrow");
    access(1'b1, 8'h04, 3'd4, 32'h0000_0000, "R3 data wide");
    access(1'b0, 8'h04, 3'd1, 32'h0, "R3 data byte");
    access(1'b1, 8'h22, 3'd4, 32'h0, "R5 both bad");
    access(1'b1, 8'h22, 3'd2, 32'h0, "R4 unmapped");
    access(1'b1, 8'h1D, 3'd2, 32'h0, "R4 misaligned");
    access(1'b0, 8'h1C, 3'd4, 32'h0, "R3 mux intact");
    access(1'b0, 8'h04, 3'd2, 32'h0, "R4 data intact");

    // R11: qualification by three masks.
    access(1'b1, 8'h00, 3'd2, 32'h0000_FF0F, "R11 fer");
    access(1'b1, 8'h18, 3'd2, 32'h0000_F3F3, "R11 inen");
    access(1'b1, 8'h10, 3'd2, 32'h0000_1111, "R11 dir");
    input_check(16'hFFFF, "R11 all high");
    input_check(16'h0000, "R11 all low");
    input_check(16'hA5C3, "R11 pattern");

    // Random mix.
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  a;
      logic [2:0]  s;
      logic [31:0] w;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(($urandom % 8) * 4);
      case ($urandom % 6)
        0: s = 3'd1;
        1: s = 3'd4;
        2: s = 3'd3;
        default: s = 3'd2;
      endcase
      if (a == 8'h1C && ($urandom % 2 == 0)) s = 3'd4;
      w = $urandom;
      access(($urandom % 2) == 1, a, s, w, "random");
      if (n % 8 == 0) input_check(16'($urandom), "random R11");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule